// File: doc/BRIEF.md
# Power-Gating Sequencer with State Retention

This block lives in the always-on part of a chip and takes a single switchable domain through shutdown and wake-up. On a sleep request it fences the domain's outputs with isolation clamps, copies the domain's registers into always-on shadow storage, latches a retention hold and opens the power switch. It then waits for the switch to report that power is gone. On a wake request it closes the switch, waits for the power-good acknowledge, copies the shadow contents back, drops the hold and finally lifts isolation.

The domain side is modelled by a small register bank. While the domain is unpowered those registers hold their reset values, so simulation never sees unknowns. Each isolated output bit is clamped to the reset value of the register bit that drives it. If an acknowledge does not arrive within a programmable number of cycles, the sequencer parks in an error state, which only a reset clears. Every control output is a register driven from the always-on clock domain.

Top module: `pgs_top`

## Requirements
- R1: After synchronous reset the sequencer is in the running state: `iso_en`=0, `save_p`=0, `ret_hold`=0, `sw_en`=1, `restore_p`=0, `busy`=0, `err`=0, and both `dom_q` and `dom_out` equal the parameter `RST_VAL`.
- R2: A `sleep_req` seen in the running state starts the shutdown. On the following cycles, in order: `iso_en` rises; one cycle later `save_p` is high for exactly one cycle; then `ret_hold` rises; then `sw_en` falls. The sequencer then waits for `sw_ack`=0 and enters the off state, where `busy`=0.
- R3: A `wake_req` seen in the off state raises `sw_en` and waits for `sw_ack`=1. Then `restore_p` is high for exactly one cycle, then `ret_hold` falls, and one cycle later `iso_en` falls and the running state is reached.
- R4: While `iso_en`=1, each bit of `dom_out` equals the matching bit of `RST_VAL`. That is, every clamp value is the reset value of the register bit behind it. While `iso_en`=0, `dom_out` equals `dom_q`.
- R5: On the clock edge after any cycle in which `sw_ack`=0, every domain register reads its `RST_VAL` field on `dom_q`.
- R6: The contents captured in the save cycle appear on `dom_q` on the cycle after the restore pulse and stay there after wake-up completes.
- R7: Whenever `sw_en`=0, both `ret_hold` and `iso_en` are 1 and do not change.
- R8: `busy` is 1 in every sequencing state and 0 in the running, off and error states. `sleep_req` and `wake_req` have no effect while `busy`=1. In the running state `wake_req` does nothing, and in the off state `sleep_req` does nothing.
- R9: If the awaited `sw_ack` level is still absent after `to_limit` consecutive cycles in a wait state, the sequencer enters the error state: `err`=1, `iso_en`=1, `ret_hold`=1, `sw_en`=0, `busy`=0. This state persists until reset, and requests are ignored in it.
- R10: With `wr_en`=1 and `sw_ack`=1, register `wr_idx` (field `wr_idx*W` in `dom_q`) takes `wr_data` on the next edge. Writes made while `sw_ack`=0 are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to power the domain down |
| wake_req | input | 1 | Request to power the domain up |
| to_limit | input | TW | Acknowledge timeout in cycles |
| sw_ack | input | 1 | Power switch status, 1 = domain powered |
| wr_en | input | 1 | Domain register write strobe |
| wr_idx | input | AW | Domain register index |
| wr_data | input | W | Domain register write data |
| iso_en | output | 1 | Isolation enable |
| save_p | output | 1 | One-cycle save strobe into shadow storage |
| ret_hold | output | 1 | Retention hold |
| sw_en | output | 1 | Power switch enable |
| restore_p | output | 1 | One-cycle restore strobe from shadow storage |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Acknowledge timeout occurred |
| dom_q | output | NREG*W | Domain register contents before isolation |
| dom_out | output | NREG*W | Isolated domain outputs |

## Verification
Two full sleep and wake cycles are run, with different register contents and switch delays of three cycles and one cycle. This separates the restore of saved data from a reload of reset values, and shows that the strobes follow the acknowledge and not a fixed count. Requests are pulsed inside busy windows, at the same time as each other, and in states where they do not apply. Writes are attempted while the domain is off, so that ignored stimulus shows at `dom_q`. A stuck switch with a short limit drives the timeout path, and a later reset shows that the error state is left only through reset.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [3:0] {
    ST_RUN    = 4'd0,
    ST_ISO    = 4'd1,
    ST_SAVE   = 4'd2,
    ST_HOLD   = 4'd3,
    ST_PDN    = 4'd4,
    ST_OFF    = 4'd5,
    ST_PUP    = 4'd6,
    ST_REST   = 4'd7,
    ST_UNHOLD = 4'd8,
    ST_ERR    = 4'd9
  } pg_state_e;

  typedef struct packed {
    logic iso;
    logic save;
    logic hold;
    logic sw;
    logic rest;
    logic busy;
    logic err;
  } pg_ctl_t;

  function automatic pg_ctl_t pg_decode(pg_state_e s);
    pg_ctl_t c;
    c = '0;
    case (s)
      ST_RUN:    begin c.sw = 1'b1; end
      ST_ISO:    begin c.iso = 1'b1; c.sw = 1'b1; c.busy = 1'b1; end
      ST_SAVE:   begin c.iso = 1'b1; c.save = 1'b1; c.sw = 1'b1; c.busy = 1'b1; end
      ST_HOLD:   begin c.iso = 1'b1; c.hold = 1'b1; c.sw = 1'b1; c.busy = 1'b1; end
      ST_PDN:    begin c.iso = 1'b1; c.hold = 1'b1; c.busy = 1'b1; end
      ST_OFF:    begin c.iso = 1'b1; c.hold = 1'b1; end
      ST_PUP:    begin c.iso = 1'b1; c.hold = 1'b1; c.sw = 1'b1; c.busy = 1'b1; end
      ST_REST:   begin c.iso = 1'b1; c.hold = 1'b1; c.sw = 1'b1; c.rest = 1'b1; c.busy = 1'b1; end
      ST_UNHOLD: begin c.iso = 1'b1; c.sw = 1'b1; c.busy = 1'b1; end
      ST_ERR:    begin c.iso = 1'b1; c.hold = 1'b1; c.err = 1'b1; end
      default:   begin c.iso = 1'b1; c.hold = 1'b1; c.err = 1'b1; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pgs_wait_timer.sv
module pgs_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          waiting,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
  assign expired = waiting && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !waiting) cnt_q <= '0;
    else if (!expired)   cnt_q <= cnt_q + 1'b1;
  end

  // a running count never exceeds the limit it is compared to
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    waiting |-> ({1'b0, cnt_q} < {1'b0, limit}) || (limit == '0));

endmodule

// File: rtl/pgs_seq_fsm.sv
module pgs_seq_fsm
  import pgs_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic [TW-1:0] limit,
  input  logic          sw_ack,
  output pg_ctl_t       ctl
);

  pg_state_e state_q, state_d;
  logic      waiting, expired;

  assign waiting = (state_q == ST_PDN && sw_ack) || (state_q == ST_PUP && !sw_ack);

  pgs_wait_timer #(.TW(TW)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .waiting (waiting),
    .limit   (limit),
    .expired (expired)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:    if (sleep_req) state_d = ST_ISO;
      ST_ISO:    state_d = ST_SAVE;
      ST_SAVE:   state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_PDN;
      ST_PDN:    if (!sw_ack) state_d = ST_OFF;
                 else if (expired) state_d = ST_ERR;
      ST_OFF:    if (wake_req) state_d = ST_PUP;
      ST_PUP:    if (sw_ack) state_d = ST_REST;
                 else if (expired) state_d = ST_ERR;
      ST_REST:   state_d = ST_UNHOLD;
      ST_UNHOLD: state_d = ST_RUN;
      ST_ERR:    state_d = ST_ERR;
      default:   state_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      ctl     <= pg_decode(ST_RUN);
    end else begin
      state_q <= state_d;
      ctl     <= pg_decode(state_d);
    end
  end

  assert_save_under_iso_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.save |-> ctl.iso && ctl.sw && !ctl.hold);
  assert_save_single_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.save |=> !ctl.save && ctl.hold);
  assert_restore_powered_R3: assert property (@(posedge clk) disable iff (rst)
    ctl.rest |-> ctl.sw && sw_ack && ctl.hold && ctl.iso);
  assert_restore_single_R3: assert property (@(posedge clk) disable iff (rst)
    ctl.rest |=> !ctl.rest && !ctl.hold && ctl.iso);
  assert_hold_while_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!ctl.sw && $past(!ctl.sw)) |-> ctl.hold && ctl.iso && $stable(ctl.hold) && $stable(ctl.iso));
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.busy) |-> $past(state_q == ST_RUN || state_q == ST_OFF));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ctl.err |=> ctl.err && !ctl.busy);

endmodule

// File: rtl/pgs_ret_bank.sv
module pgs_ret_bank #(
  parameter int                NREG    = 4,
  parameter int                W       = 8,
  parameter logic [NREG*W-1:0] RST_VAL = '0,
  localparam int               AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              save,
  input  logic              restore,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [W-1:0]      wr_data,
  output logic [NREG*W-1:0] regs_o
);

  logic [NREG-1:0][W-1:0] live_q;
  logic [NREG-1:0][W-1:0] shad_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // domain-side register: loses content when unpowered
    always_ff @(posedge clk) begin
      if (rst || !pwr_good)                    live_q[g] <= RST_VAL[g*W +: W];
      else if (restore)                        live_q[g] <= shad_q[g];
      else if (wr_en && wr_idx == AW'(g))      live_q[g] <= wr_data;
    end
    // always-on shadow copy
    always_ff @(posedge clk) begin
      if (rst)       shad_q[g] <= RST_VAL[g*W +: W];
      else if (save) shad_q[g] <= live_q[g];
    end
  end

  assign regs_o = live_q;

  assert_restore_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (restore && pwr_good) |=> regs_o == $past(shad_q));

endmodule

// File: rtl/pgs_iso_clamp.sv
module pgs_iso_clamp #(
  parameter int               WIDTH = 32,
  parameter logic [WIDTH-1:0] CLAMP = '0
) (
  input  logic             iso,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (CLAMP[b]) begin : g_hi
      assign dout[b] = din[b] | iso;
    end else begin : g_lo
      assign dout[b] = din[b] & ~iso;
    end
  end

endmodule

// File: rtl/pgs_top.sv
module pgs_top
  import pgs_pkg::*;
#(
  parameter int                NREG    = 4,
  parameter int                W       = 8,
  parameter int                TW      = 8,
  parameter logic [NREG*W-1:0] RST_VAL = 32'hC300FF5A,
  localparam int               AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic [TW-1:0]     to_limit,
  input  logic              sw_ack,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [W-1:0]      wr_data,
  output logic              iso_en,
  output logic              save_p,
  output logic              ret_hold,
  output logic              sw_en,
  output logic              restore_p,
  output logic              busy,
  output logic              err,
  output logic [NREG*W-1:0] dom_q,
  output logic [NREG*W-1:0] dom_out
);

  pg_ctl_t ctl;

  pgs_seq_fsm #(.TW(TW)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .limit     (to_limit),
    .sw_ack    (sw_ack),
    .ctl       (ctl)
  );

  pgs_ret_bank #(.NREG(NREG), .W(W), .RST_VAL(RST_VAL)) bank_i (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (sw_ack),
    .save     (ctl.save),
    .restore  (ctl.rest),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .regs_o   (dom_q)
  );

  pgs_iso_clamp #(.WIDTH(NREG*W), .CLAMP(RST_VAL)) clamp_i (
    .iso  (ctl.iso),
    .din  (dom_q),
    .dout (dom_out)
  );

  assign iso_en    = ctl.iso;
  assign save_p    = ctl.save;
  assign ret_hold  = ctl.hold;
  assign sw_en     = ctl.sw;
  assign restore_p = ctl.rest;
  assign busy      = ctl.busy;
  assign err       = ctl.err;

  assert_clamp_value_R4: assert property (@(posedge clk) disable iff (rst)
    iso_en |-> dom_out == RST_VAL);
  assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
    !iso_en |-> dom_out == dom_q);
  assert_off_reset_R5: assert property (@(posedge clk) disable iff (rst)
    !sw_ack |=> dom_q == RST_VAL);

endmodule

// File: tb/pgs_top_tb_top.sv
module pgs_top_tb_top;

  localparam int          NREG = 4;
  localparam int          W    = 8;
  localparam int          TW   = 8;
  localparam int          AW   = 2;
  localparam logic [31:0] RV   = 32'hC300FF5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, wake_req = 1'b0, wr_en = 1'b0;
  logic [TW-1:0] to_limit = 8'd8;
  logic [AW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_data = '0;
  logic sw_ack;
  logic iso_en, save_p, ret_hold, sw_en, restore_p, busy, err;
  logic [31:0] dom_q, dom_out;

  always #5 clk = ~clk;

  pgs_top #(.NREG(NREG), .W(W), .TW(TW), .RST_VAL(RV)) dut_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .to_limit(to_limit), .sw_ack(sw_ack), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .iso_en(iso_en), .save_p(save_p), .ret_hold(ret_hold),
    .sw_en(sw_en), .restore_p(restore_p), .busy(busy), .err(err),
    .dom_q(dom_q), .dom_out(dom_out)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // ---------- power switch model ----------
  int  sw_dly = 3;
  bit  sw_stuck = 1'b0;
  int  sw_cnt = 0;
  always @(posedge clk) begin
    if (rst) begin
      sw_ack <= 1'b1; sw_cnt <= 0;
    end else if (!sw_stuck && sw_en != sw_ack) begin
      if (sw_cnt + 1 >= sw_dly) begin sw_ack <= sw_en; sw_cnt <= 0; end
      else sw_cnt <= sw_cnt + 1;
    end else sw_cnt <= 0;
  end

  // ---------- behavioural reference: phase numbers and an array ----------
  // phases: 0 run,1 iso,2 save,3 hold,4 wait-off,5 off,6 wait-on,7 restore,8 unhold,9 error
  int       ph = 0, waited = 0;
  bit [7:0] mreg [4];
  bit [7:0] mshd [4];

  always @(posedge clk) begin
    if (rst) begin
      ph <= 0; waited <= 0;
      for (int i = 0; i < 4; i++) begin mreg[i] <= RV[i*8 +: 8]; mshd[i] <= RV[i*8 +: 8]; end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (!sw_ack) mreg[i] <= RV[i*8 +: 8];
        else if (ph == 7) mreg[i] <= mshd[i];
        else if (wr_en && int'(wr_idx) == i) mreg[i] <= wr_data;
        if (ph == 2) mshd[i] <= mreg[i];
      end
      waited <= 0;
      case (ph)
        0: if (sleep_req) ph <= 1;
        1, 2, 3, 7: ph <= ph + 1;
        8: ph <= 0;
        4: if (!sw_ack) ph <= 5;
           else if (waited + 1 >= int'(to_limit)) ph <= 9;
           else waited <= waited + 1;
        5: if (wake_req) ph <= 6;
        6: if (sw_ack) ph <= 7;
           else if (waited + 1 >= int'(to_limit)) ph <= 9;
           else waited <= waited + 1;
        default: ph <= 9;
      endcase
    end
  end

  function automatic bit [31:0] mpack();
    return {mreg[3], mreg[2], mreg[1], mreg[0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit e_iso, e_save, e_hold, e_sw, e_rest, e_busy, e_err;
      e_iso  = (ph != 0);
      e_save = (ph == 2);
      e_hold = (ph >= 3 && ph <= 7) || ph == 9;
      e_sw   = !(ph == 4 || ph == 5 || ph == 9);
      e_rest = (ph == 7);
      e_busy = (ph != 0 && ph != 5 && ph != 9);
      e_err  = (ph == 9);
      chk(iso_en == e_iso, "R2 iso_en", 32'(iso_en), 32'(e_iso));
      chk(save_p == e_save, "R2 save_p", 32'(save_p), 32'(e_save));
      chk(ret_hold == e_hold, "R7 ret_hold", 32'(ret_hold), 32'(e_hold));
      chk(sw_en == e_sw, "R3 sw_en", 32'(sw_en), 32'(e_sw));
      chk(restore_p == e_rest, "R3 restore_p", 32'(restore_p), 32'(e_rest));
      chk(busy == e_busy, "R8 busy", 32'(busy), 32'(e_busy));
      chk(err == e_err, "R9 err", 32'(err), 32'(e_err));
      chk(dom_q == mpack(), "R6 dom_q", dom_q, mpack());
      chk(dom_out == (e_iso ? RV : mpack()), "R4 dom_out", dom_out, e_iso ? RV : mpack());
    end
  end

  // ---------- stimulus helpers ----------
  task automatic pulse_sleep(); @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0; endtask
  task automatic pulse_wake();  @(negedge clk); wake_req = 1;  @(negedge clk); wake_req = 0;  endtask
  task automatic pulse_both();  @(negedge clk); sleep_req = 1; wake_req = 1; @(negedge clk); sleep_req = 0; wake_req = 0; endtask
  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_idx = AW'(idx); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(iso_en == 0 && ret_hold == 0 && sw_en == 1 && busy == 0 && err == 0, "R1 controls",
        {25'd0, iso_en, save_p, ret_hold, sw_en, restore_p, busy, err}, 32'h0000_0008);
    chk(dom_q == RV && dom_out == RV, "R1 data", dom_q, RV);

    // R10 writes while powered
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'h44);
    @(negedge clk);
    chk(dom_q == 32'h44332211, "R10 write", dom_q, 32'h44332211);
    // R8 wake ignored in run
    pulse_wake(); @(negedge clk);
    chk(busy == 0 && iso_en == 0, "R8 wake in run", 32'(busy), 0);

    // first shutdown, requests during busy must be ignored (R8)
    pulse_sleep();
    chk(busy == 1 && iso_en == 1 && save_p == 0, "R2 iso first", 32'(iso_en), 1);
    pulse_wake(); pulse_sleep();
    wait_idle();
    chk(sw_en == 0 && ret_hold == 1 && iso_en == 1 && sw_ack == 0, "R2 off reached",
        {28'd0, sw_en, ret_hold, iso_en, sw_ack}, 32'h6);
    chk(dom_q == RV, "R5 off values", dom_q, RV);
    chk(dom_out == RV, "R4 clamp off", dom_out, RV);
    wr(1, 8'hFF); @(negedge clk);
    chk(dom_q == RV, "R10 write ignored off", dom_q, RV);
    pulse_sleep(); @(negedge clk);
    chk(busy == 0 && sw_en == 0, "R8 sleep in off", 32'(busy), 0);

    // wake-up and restore
    pulse_wake();
    wait_idle();
    @(negedge clk);
    chk(iso_en == 0 && sw_en == 1 && ret_hold == 0, "R3 run again", 32'(iso_en), 0);
    chk(dom_q == 32'h44332211, "R6 restored", dom_q, 32'h44332211);
    chk(dom_out == 32'h44332211, "R4 pass through", dom_out, 32'h44332211);

    // second cycle: new data, faster switch, simultaneous requests
    sw_dly = 1;
    wr(0, 8'hA0); wr(2, 8'h0B);
    pulse_both();
    wait_idle();
    chk(sw_en == 0 && dom_q == RV, "R5 second off", dom_q, RV);
    pulse_wake();
    wait_idle();
    @(negedge clk);
    chk(dom_q == 32'h440B22A0, "R6 second restore", dom_q, 32'h440B22A0);

    // timeout: switch never acknowledges power-off
    to_limit = 8'd5; sw_stuck = 1;
    pulse_sleep();
    for (int k = 0; k < 40 && !err; k++) @(negedge clk);
    chk(err == 1 && busy == 0 && sw_en == 0 && iso_en == 1 && ret_hold == 1, "R9 error state",
        {27'd0, err, busy, sw_en, iso_en, ret_hold}, 32'h13);
    pulse_wake(); pulse_sleep(); repeat (3) @(negedge clk);
    chk(err == 1 && sw_en == 0, "R9 sticky", 32'(err), 1);

    // recovery through reset
    sw_stuck = 0; rst = 1; repeat (2) @(negedge clk); rst = 0; @(negedge clk);
    chk(err == 0 && sw_en == 1 && iso_en == 0 && dom_q == RV, "R1 after error", dom_q, RV);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R8 actual=%h expected=%h", 32'(busy), 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule